// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is an 8-bit accumulator processor. Every assembly instruction, fetch included, runs as a fixed list of micro-operations. Each micro-operation takes one clock and moves one value over a single internal bus. Architectural state is the accumulator, the program counter, a four-flag condition code and a three-entry internal return stack. Working registers hold the instruction, the second instruction word, the ALU operand and a memory buffer.

External memory is reached through registered address pins, bidirectional data pins, a valid-address strobe and a read/write select. Every access takes two micro-steps. The first places the address and raises the strobe. The second moves the data and drops the strobe. A write is committed by the memory when it sees the strobe fall after a cycle in which the select read write and the data pins were driven.

The core brings out its accumulator, program counter, flags, the top of its stack and a pulse marking each instruction boundary. An integrating test environment can follow execution with these, one instruction at a time.

Top module: `ucore_top`

## Requirements
- R1: While reset is held, ACC, PC and CC are zero, the stack is empty (top reads zero), the strobe is low, the select reads 1 (read) and the boundary flag is high.
- R2: Each instruction opens with a three-step fetch: the strobe rises with select 1 and address equal to PC, PC then advances by one, the next step reads the opcode, and the third loads IR. A two-word instruction advances PC once more for its second word, which is held in ROP.
- R3: A read access holds the strobe high for exactly one cycle (select 1). The core latches the data pins at the end of that cycle and drops the strobe.
- R4: A write access raises the strobe with select 0 for exactly one cycle. The core drives the data pins only during that cycle, and exactly one memory write takes place per store.
- R5: Opcode bit 7 chooses the mode. A value of 0 is immediate, where the operand is the second word. A value of 1 is direct, where the operand is the memory byte at the address given by the second word.
- R6: ADD (function code 0x02) forms the 8-bit sum of ACC and the operand. It sets CC to {N,Z,C,O} in bits 3..0: N is sum bit 7, Z is sum equal to zero, C is the carry out of bit 7, and O is signed overflow.
- R7: LOAD (function code 0x01) copies the operand into ACC and leaves CC unchanged.
- R8: STO (function code 0x03, mode bit ignored) writes ACC to the address given by its second word.
- R9: JSR (function code 0x04) pushes {4'b0000,CC}, then pushes the return address (the address after its second word), then loads PC with the second word.
- R10: RET (opcode 0x05, one word) pops PC, then pops a byte whose low four bits become CC.
- R11: The stack holds three entries. A push onto a full stack discards the oldest entry. A pop of an empty stack yields zero.
- R12: Instruction boundaries are spaced 8 cycles for immediate LOAD/ADD, 10 for direct LOAD/ADD, 9 for STO and JSR, 5 for RET and 4 for any other opcode.
- R13: Any opcode whose low seven bits are not 0x01 to 0x05 acts as a one-word no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_ad | output | 8 | Memory address pins |
| mem_data | inout | 8 | Bidirectional memory data pins |
| mem_vma | output | 1 | Valid-address strobe |
| mem_rw | output | 1 | Access select, 1 read, 0 write |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 8 | Program counter |
| cc_o | output | 4 | Flags {N,Z,C,O} |
| stk_top_o | output | 8 | Top stack entry, zero when empty |
| fetch_o | output | 1 | High in the first step of each instruction |

## Verification
The hardest situations are the stack overflow and the underflow. The first needs two nested calls before any return, so that the fourth push drops the oldest flag byte. The second needs a return executed with nothing left on the stack. The stimulus program nests two JSRs, returns twice, and then runs a RET on an empty stack. Flags are restored from a zero byte and PC wraps to address 0. Execution then repeats over memory the program itself has changed through earlier stores.

// File: rtl/ucore_pkg.sv
package ucore_pkg;

  localparam int DW = 8;
  localparam int CCW = 4;

  // Function codes in opcode bits 6..0; bit 7 selects direct mode
  localparam logic [6:0] FN_LOAD = 7'h01;
  localparam logic [6:0] FN_ADD  = 7'h02;
  localparam logic [6:0] FN_STO  = 7'h03;
  localparam logic [6:0] FN_JSR  = 7'h04;
  localparam logic [6:0] FN_RET  = 7'h05;

  localparam int FETCH_STEPS = 3;

  typedef enum logic [4:0] {
    MI_NOP, MI_AD_PC, MI_READ, MI_LD_IR, MI_LD_ROP, MI_LD_RD_IM,
    MI_AD_ROP, MI_LD_RD, MI_ADD, MI_MOV, MI_ACC_TMEM, MI_AD_ROP_WR,
    MI_WRITE, MI_PUSH_CC, MI_PUSH_PC, MI_JMP, MI_POP_PC, MI_POP_CC
  } uop_e;

  typedef struct packed {
    uop_e op;
    logic last;
  } micro_t;

  typedef struct packed {
    logic [DW-1:0]  sum;
    logic [CCW-1:0] flags;   // {N,Z,C,O}
  } alu_res_t;

  function automatic alu_res_t add8(input logic [DW-1:0] a, input logic [DW-1:0] b);
    alu_res_t r;
    logic [DW:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    r.sum = wide[DW-1:0];
    r.flags[3] = wide[DW-1];
    r.flags[2] = (wide[DW-1:0] == '0);
    r.flags[1] = wide[DW];
    r.flags[0] = (a[DW-1] == b[DW-1]) && (wide[DW-1] != a[DW-1]);
    return r;
  endfunction

  // Steps after the shared prefix (address, read, load ROP)
  function automatic micro_t tail_step(input logic [6:0] fn, input logic direct,
                                       input logic [3:0] j);
    micro_t m;
    m.op = MI_NOP;
    m.last = 1'b1;
    if (fn == FN_LOAD || fn == FN_ADD) begin
      if (!direct) begin
        m.op = (j == 4'd0) ? MI_LD_RD_IM : ((fn == FN_ADD) ? MI_ADD : MI_MOV);
        m.last = (j != 4'd0);
      end else begin
        case (j)
          4'd0: begin m.op = MI_AD_ROP; m.last = 1'b0; end
          4'd1: begin m.op = MI_READ;   m.last = 1'b0; end
          4'd2: begin m.op = MI_LD_RD;  m.last = 1'b0; end
          default: m.op = (fn == FN_ADD) ? MI_ADD : MI_MOV;
        endcase
      end
    end else if (fn == FN_STO) begin
      case (j)
        4'd0: begin m.op = MI_ACC_TMEM;  m.last = 1'b0; end
        4'd1: begin m.op = MI_AD_ROP_WR; m.last = 1'b0; end
        default: m.op = MI_WRITE;
      endcase
    end else if (fn == FN_JSR) begin
      case (j)
        4'd0: begin m.op = MI_PUSH_CC; m.last = 1'b0; end
        4'd1: begin m.op = MI_PUSH_PC; m.last = 1'b0; end
        default: m.op = MI_JMP;
      endcase
    end
    return m;
  endfunction

  function automatic micro_t exec_step(input logic [DW-1:0] opc, input logic [3:0] k);
    micro_t m;
    logic [6:0] fn;
    fn = opc[6:0];
    m.op = MI_NOP;
    m.last = 1'b1;
    if (fn == FN_RET) begin
      m.op = (k == 4'd0) ? MI_POP_PC : MI_POP_CC;
      m.last = (k != 4'd0);
    end else if (fn == FN_LOAD || fn == FN_ADD || fn == FN_STO || fn == FN_JSR) begin
      m.last = 1'b0;
      case (k)
        4'd0: m.op = MI_AD_PC;
        4'd1: m.op = MI_READ;
        4'd2: m.op = MI_LD_ROP;
        default: m = tail_step(fn, opc[DW-1], k - 4'd3);
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/ucore_seq.sv
module ucore_seq
  import ucore_pkg::*;
#(
  parameter int UPC_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ir_i,
  output uop_e          uop_o,
  output logic          fetch_o
);
  localparam logic [UPC_W-1:0] FETCH_LAST = UPC_W'(FETCH_STEPS - 1);

  logic [UPC_W-1:0] upc_q;
  micro_t           cur_w;
  logic [3:0]       k_w;

  assign k_w = 4'(upc_q - UPC_W'(FETCH_STEPS));

  always_comb begin
    if (upc_q == '0) begin
      cur_w.op = MI_AD_PC;   cur_w.last = 1'b0;
    end else if (upc_q < FETCH_LAST) begin
      cur_w.op = MI_READ;    cur_w.last = 1'b0;
    end else if (upc_q == FETCH_LAST) begin
      cur_w.op = MI_LD_IR;   cur_w.last = 1'b0;
    end else begin
      cur_w = exec_step(ir_i, k_w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          upc_q <= '0;
    else if (cur_w.last) upc_q <= '0;
    else                 upc_q <= upc_q + 1'b1;
  end

  assign uop_o   = cur_w.op;
  assign fetch_o = (upc_q == '0);

  // R12
  seq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_o == MI_WRITE || uop_o == MI_JMP || uop_o == MI_POP_CC) |=> fetch_o);
endmodule

// File: rtl/ucore_stack.sv
module ucore_stack #(
  parameter int DEPTH = 3,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  ent_q [DEPTH];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (push_i) begin
      cnt_q <= (cnt_q == FULL) ? cnt_q : cnt_q + 1'b1;
    end else if (pop_i) begin
      cnt_q <= (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
    end
  end

  // Entry 0 is the top; the bottom entry falls off on a full push,
  // and pops shift zeros in from the bottom
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (push_i) begin
        if (g == 0) ent_q[g] <= din_i;
        else        ent_q[g] <= ent_q[(g == 0) ? 0 : g - 1];
      end else if (pop_i) begin
        if (g == DEPTH - 1) ent_q[g] <= '0;
        else                ent_q[g] <= ent_q[(g == DEPTH - 1) ? g : g + 1];
      end
    end
  end

  assign top_o = ent_q[0];

  // R11
  stk_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && cnt_q == FULL) |=> (cnt_q == FULL && top_o == $past(din_i)));
  // R11
  stk_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && cnt_q == '0) |=> (top_o == '0));
endmodule

// File: rtl/ucore_alu.sv
module ucore_alu
  import ucore_pkg::*;
(
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  output logic [DW-1:0]  sum_o,
  output logic [CCW-1:0] flags_o
);
  alu_res_t res_w;
  assign res_w   = add8(a_i, b_i);
  assign sum_o   = res_w.sum;
  assign flags_o = res_w.flags;
endmodule

// File: rtl/ucore_top.sv
module ucore_top
  import ucore_pkg::*;
#(
  parameter int STACK_DEPTH = 3,
  parameter int UPC_W       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [7:0]    mem_ad,
  inout  wire  [7:0]    mem_data,
  output logic          mem_vma,
  output logic          mem_rw,
  output logic [7:0]    acc_o,
  output logic [7:0]    pc_o,
  output logic [3:0]    cc_o,
  output logic [7:0]    stk_top_o,
  output logic          fetch_o
);
  logic [DW-1:0]  acc_q, pc_q, ir_q, rop_q, rd_q, tmem_q, ad_q;
  logic [CCW-1:0] cc_q;
  logic           vma_q, rw_q, drive_q;

  uop_e           uop_w;
  logic           fetch_w;
  logic [DW-1:0]  bus_w;
  logic [DW-1:0]  sum_w, top_w;
  logic [CCW-1:0] flags_w;
  logic           push_w, pop_w, rd_latch_w, wr_start_w;

  ucore_seq #(.UPC_W(UPC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ir_i(ir_q), .uop_o(uop_w), .fetch_o(fetch_w)
  );

  ucore_alu u_alu (
    .a_i(acc_q), .b_i(rd_q), .sum_o(sum_w), .flags_o(flags_w)
  );

  assign push_w = (uop_w == MI_PUSH_CC) || (uop_w == MI_PUSH_PC);
  assign pop_w  = (uop_w == MI_POP_PC)  || (uop_w == MI_POP_CC);

  ucore_stack #(.DEPTH(STACK_DEPTH), .W(DW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push_i(push_w), .pop_i(pop_w),
    .din_i(bus_w), .top_o(top_w)
  );

  // Single internal bus source per micro-operation
  always_comb begin
    case (uop_w)
      MI_AD_PC, MI_PUSH_PC:                       bus_w = pc_q;
      MI_AD_ROP, MI_AD_ROP_WR, MI_LD_RD_IM, MI_JMP: bus_w = rop_q;
      MI_LD_IR, MI_LD_ROP, MI_LD_RD:              bus_w = tmem_q;
      MI_ACC_TMEM:                                bus_w = acc_q;
      MI_MOV:                                     bus_w = rd_q;
      MI_PUSH_CC:                                 bus_w = {{(DW-CCW){1'b0}}, cc_q};
      MI_POP_PC, MI_POP_CC:                       bus_w = top_w;
      default:                                    bus_w = '0;
    endcase
  end

  assign rd_latch_w = (uop_w == MI_READ);
  assign wr_start_w = (uop_w == MI_AD_ROP_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0; pc_q <= '0; ir_q <= '0; rop_q <= '0; rd_q <= '0;
      tmem_q <= '0; ad_q <= '0; cc_q <= '0;
      vma_q <= 1'b0; rw_q <= 1'b1; drive_q <= 1'b0;
    end else begin
      case (uop_w)
        MI_AD_PC: begin
          vma_q <= 1'b1; rw_q <= 1'b1; ad_q <= bus_w; pc_q <= pc_q + 1'b1;
        end
        MI_AD_ROP: begin
          vma_q <= 1'b1; rw_q <= 1'b1; ad_q <= bus_w;
        end
        MI_READ: begin
          vma_q <= 1'b0; rw_q <= 1'b1; tmem_q <= mem_data;
        end
        MI_LD_IR:    ir_q  <= bus_w;
        MI_LD_ROP:   rop_q <= bus_w;
        MI_LD_RD_IM,
        MI_LD_RD:    rd_q  <= bus_w;
        MI_ADD: begin
          acc_q <= sum_w; cc_q <= flags_w;
        end
        MI_MOV:      acc_q <= bus_w;
        MI_ACC_TMEM: tmem_q <= bus_w;
        MI_AD_ROP_WR: begin
          vma_q <= 1'b1; rw_q <= 1'b0; ad_q <= bus_w; drive_q <= 1'b1;
        end
        MI_WRITE: begin
          vma_q <= 1'b0; rw_q <= 1'b1; drive_q <= 1'b0;
        end
        MI_JMP, MI_POP_PC: pc_q <= bus_w;
        MI_POP_CC:   cc_q <= bus_w[CCW-1:0];
        default: ;
      endcase
    end
  end

  assign mem_data  = drive_q ? tmem_q : 8'hzz;
  assign mem_ad    = ad_q;
  assign mem_vma   = vma_q;
  assign mem_rw    = rw_q;
  assign acc_o     = acc_q;
  assign pc_o      = pc_q;
  assign cc_o      = cc_q;
  assign stk_top_o = top_w;
  assign fetch_o   = fetch_w;

  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_w |=> (mem_vma && mem_rw && mem_ad == $past(pc_q) && pc_q == $past(pc_q) + 8'd1));
  // R3
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_vma) && mem_rw) |-> rd_latch_w);
  // R3
  rd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch_w |=> !mem_vma);
  // R4
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> (mem_vma && !mem_rw));
  // R4
  wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_w |=> (drive_q && $stable(acc_q)) ##1 (!drive_q && !mem_vma));
endmodule

// File: tb/ucore_top_bench.sv
module ucore_top_bench;
  localparam int N_INSTR = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  wire  [7:0] data_w;
  logic [7:0] ad_w, acc_w, pc_w, top_w;
  logic [3:0] cc_w;
  logic       vma_w, rw_w, fetch_w;

  ucore_top u_ucore_top (
    .clk(clk), .rst_n(rst_n), .mem_ad(ad_w), .mem_data(data_w),
    .mem_vma(vma_w), .mem_rw(rw_w), .acc_o(acc_w), .pc_o(pc_w),
    .cc_o(cc_w), .stk_top_o(top_w), .fetch_o(fetch_w)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory seen by the core, and the reference copy
  logic [7:0] mem [256];
  logic [7:0] rmem [256];

  assign data_w = (vma_w && rw_w) ? mem[ad_w] : 8'hzz;

  logic       p_vma = 1'b0, p_rw = 1'b1;
  logic [7:0] p_ad = '0, p_data = '0;
  int         writes_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_vma && !p_rw && !vma_w) begin
        mem[p_ad] = p_data;
        writes_seen++;
      end
      // R3: strobe is never high two samples running
      if (vma_w && rw_w) check("R3 strobe width", {31'd0, p_vma}, 32'd0);
    end
    p_vma = vma_w; p_rw = rw_w; p_ad = ad_w; p_data = data_w;
  end

  // Reference model and scoreboard
  typedef struct packed {
    logic [7:0] acc, pc, top, cyc;
    logic [3:0] cc;
  } exp_t;
  exp_t       sb_q[$];
  logic [7:0] racc = '0, rpc = '0;
  logic [3:0] rcc = '0;
  logic [7:0] rstk[$];
  int         ref_writes = 0;

  function automatic logic [3:0] ref_flags(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s9;
    s9 = {1'b0, a} + {1'b0, b};
    return {s9[7], s9[7:0] == 8'd0, s9[8], (a[7] ~^ b[7]) & (a[7] ^ s9[7])};
  endfunction

  task automatic ref_push(input logic [7:0] v);
    rstk.push_front(v);
    if (rstk.size() > 3) void'(rstk.pop_back());
  endtask

  task automatic ref_pop(output logic [7:0] v);
    if (rstk.size() == 0) v = 8'd0;
    else v = rstk.pop_front();
  endtask

  task automatic drive_expect(input logic [7:0] cyc);
    exp_t e;
    e.acc = racc; e.pc = rpc; e.cc = rcc; e.cyc = cyc;
    e.top = (rstk.size() == 0) ? 8'd0 : rstk[0];
    sb_q.push_back(e);
  endtask

  task automatic ref_step();
    logic [7:0] op, w, val, t;
    logic [7:0] cyc;
    op = rmem[rpc]; rpc = rpc + 8'd1;
    cyc = 8'd4;                                  // R13
    case (op[6:0])
      7'h01, 7'h02: begin
        w = rmem[rpc]; rpc = rpc + 8'd1;
        val = op[7] ? rmem[w] : w;               // R5
        cyc = op[7] ? 8'd10 : 8'd8;
        if (op[6:0] == 7'h01) racc = val;
        else begin rcc = ref_flags(racc, val); racc = racc + val; end
      end
      7'h03: begin
        w = rmem[rpc]; rpc = rpc + 8'd1;
        rmem[w] = racc; ref_writes++; cyc = 8'd9;
      end
      7'h04: begin
        w = rmem[rpc]; rpc = rpc + 8'd1;
        ref_push({4'd0, rcc}); ref_push(rpc); rpc = w; cyc = 8'd9;
      end
      7'h05: begin
        ref_pop(t); rpc = t; ref_pop(t); rcc = t[3:0]; cyc = 8'd5;
      end
      default: ;
    endcase
    drive_expect(cyc);
  endtask

  // Monitor
  int  seen = 0;
  int  gap = 0;
  logic done = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      gap++;
      if (fetch_w) begin
        exp_t e;
        if (sb_q.size() == 0) begin
          check("R12 scoreboard empty", 32'd1, 32'd0);
        end else begin
          e = sb_q.pop_front();
          check("R7 acc", {24'd0, acc_w}, {24'd0, e.acc});
          check("R6 cc", {28'd0, cc_w}, {28'd0, e.cc});
          check("R9 R10 pc", {24'd0, pc_w}, {24'd0, e.pc});
          check("R11 stack top", {24'd0, top_w}, {24'd0, e.top});
          if (seen > 0) check("R12 instruction length", gap, {24'd0, e.cyc});
        end
        gap = 0;
        seen++;
        if (seen == N_INSTR + 1) done = 1'b1;
      end
    end
  end

  initial begin
    int mism;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    // Program: exercises both modes, flags, nested calls, overflow, empty pop
    mem[8'h00] = 8'h01; mem[8'h01] = 8'h7F;   // LOAD #7F
    mem[8'h02] = 8'h02; mem[8'h03] = 8'h01;   // ADD  #01 -> signed overflow
    mem[8'h04] = 8'h03; mem[8'h05] = 8'h40;   // STO  40
    mem[8'h06] = 8'h82; mem[8'h07] = 8'h40;   // ADD  [40] -> zero, carry
    mem[8'h08] = 8'h81; mem[8'h09] = 8'h41;   // LOAD [41]
    mem[8'h0A] = 8'h04; mem[8'h0B] = 8'h20;   // JSR  20
    mem[8'h0C] = 8'h83; mem[8'h0D] = 8'h42;   // STO  42 (mode bit ignored)
    mem[8'h0E] = 8'h7E;                       // undefined -> no-op
    mem[8'h0F] = 8'h05;                       // RET on empty stack
    mem[8'h20] = 8'h02; mem[8'h21] = 8'hFF;   // ADD  #FF
    mem[8'h22] = 8'h04; mem[8'h23] = 8'h30;   // JSR  30 -> fourth push
    mem[8'h24] = 8'h05;                       // RET
    mem[8'h30] = 8'h05;                       // RET
    mem[8'h41] = 8'hC3;
    for (int i = 0; i < 256; i++) rmem[i] = mem[i];

    drive_expect(8'd0);
    for (int i = 0; i < N_INSTR; i++) ref_step();

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 acc", {24'd0, acc_w}, 32'd0);
    check("R1 pc", {24'd0, pc_w}, 32'd0);
    check("R1 cc", {28'd0, cc_w}, 32'd0);
    check("R1 stack top", {24'd0, top_w}, 32'd0);
    check("R1 strobe", {31'd0, vma_w}, 32'd0);
    check("R1 select", {31'd0, rw_w}, 32'd1);
    check("R1 boundary", {31'd0, fetch_w}, 32'd1);
    rst_n = 1'b1;

    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    if (!done) check("R2 watchdog", 32'd1, 32'd0);

    @(negedge clk);
    @(negedge clk);
    // R4 one write per store; R8 memory image after the run
    check("R4 write count", writes_seen, ref_writes);
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== rmem[i]) mism++;
    check("R8 memory image", mism, 32'd0);
    check("R8 stored byte", {24'd0, mem[8'h42]}, 32'hC2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule